// File: doc/BRIEF.md
# I2C Slave Memory with Persistent Address Pointer

This block is a two-wire bus target that holds a small byte-wide RAM behind an address pointer. The pointer persists between transfers and advances by one after each byte. It watches the clock and data lines, detects START and STOP conditions, and compares the incoming 7-bit target address with a parameterised device address. When the address matches, it acknowledges. It drives ACK bits and read data by pulling the data line low, in open-drain fashion.

In a write transfer, the first byte after the address sets the pointer. Each byte after that is stored at the pointer, and the pointer then advances. In a read transfer, the block returns bytes starting at the current pointer for as long as the master acknowledges them. A master can therefore do a random read by sending a short write that only sets the pointer, followed by a repeated START and a read. A read with no preceding write continues from wherever the pointer was left.

Both bus lines pass through two-flop synchronisers clocked by the system clock. The block changes its data-line drive only after it has seen the clock line fall. The system clock must run several times faster than the bus clock.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset, the block drives nothing (`sda_oe_o` = 0), the memory holds 0x00 in every location, and the pointer is 0. A read issued first returns 0x00.
- R2: The first byte after a START carries the target address in bits 7:1 and the direction in bit 0 (0 = write, 1 = read), sent MSB first. On a match, the block pulls SDA low during the ninth clock (ACK = 0).
- R3: On an address mismatch, no ACK is given and the data line stays released until the next START. Bytes sent in that transfer are not stored.
- R4: In a write transfer, the first byte after the address byte is loaded into the pointer and acknowledged.
- R5: Each further write byte is stored at the pointer and acknowledged, and the pointer then advances by one.
- R6: In a read transfer, bytes are sent MSB first from successive pointer locations for as long as the master answers each byte with ACK = 0.
- R7: After the master answers a read byte with NACK = 1, the block releases SDA and drives nothing until a STOP or START.
- R8: A read transfer with no pointer-setting write before it starts at the pointer value left by the previous transfer, whether that transfer was a read or a write.
- R9: The pointer advances modulo the memory depth, so it wraps from the last location (0xFF for 256 bytes) to 0.
- R10: A START at any point, including partway through a byte, restarts address reception from bit 7.
- R11: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, several times faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 = pull the data line low, 0 = release it |

## Verification
The bound checker checks several properties on every cycle:
- the drive changes only while SCL is low;
- entering an acknowledge slot always pulls the line low;
- the block is silent when idle and when ignoring the bus;
- the pointer only ever steps by one, modulo the depth, unless it is being loaded;
- a START always puts the engine back into address reception.

Some behaviour can only be shown by the bench's bus scenarios: what data ends up stored, which bytes come back and in which order, that the pointer persists across a current-address read, the wrap from the top location, that writes after a mismatched address are discarded, and that an aborted byte followed by a START is recovered cleanly.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_ACK,
    ST_RD,
    ST_RACK,
    ST_IGN
  } st_e;
endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
  parameter int unsigned W       = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= {STAGES{RST_VAL}};
      else if (STAGES == 1) chain <= d_i[b];
      else chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2c_cond_det.sv
module i2c_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  // data edges while the clock is high both before and after
  assign start_o = scl_q & scl_s_i & sda_q & ~sda_s_i;
  assign stop_o  = scl_q & scl_s_i & ~sda_q & sda_s_i;
  assign rise_o  = ~scl_q & scl_s_i;
  assign fall_o  = scl_q & ~scl_s_i;
endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_mem_fsm.sv
module i2c_mem_fsm
  import i2c_mem_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h50,
  parameter int unsigned AW       = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          sda_s_i,
  input  logic [7:0]    rdata_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [7:0]    wdata_o,
  output logic [AW-1:0] ptr_o,
  output logic          sda_oe_o,
  output st_e           state_o
);
  st_e          state, nxt;
  logic [7:0]   sh, tx;
  logic [3:0]   cnt;
  logic         done, mack, oe;
  logic [AW-1:0] ptr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      nxt     <= ST_IDLE;
      sh      <= '0;
      tx      <= '0;
      cnt     <= '0;
      done    <= 1'b0;
      mack    <= 1'b0;
      oe      <= 1'b0;
      ptr     <= '0;
      we_o    <= 1'b0;
      waddr_o <= '0;
      wdata_o <= '0;
    end else begin
      we_o <= 1'b0;
      if (start_i) begin
        state <= ST_ADDR;
        cnt   <= '0;
        done  <= 1'b0;
        oe    <= 1'b0;
      end else if (stop_i) begin
        state <= ST_IDLE;
        cnt   <= '0;
        done  <= 1'b0;
        oe    <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            if (rise_i && !done) begin
              sh  <= {sh[6:0], sda_s_i};
              cnt <= cnt + 4'd1;
              if (cnt == 4'd7) done <= 1'b1;
            end else if (fall_i && done) begin
              done <= 1'b0;
              cnt  <= '0;
              if (state == ST_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  oe    <= 1'b1;
                  state <= ST_ACK;
                  nxt   <= sh[0] ? ST_RD : ST_PTR;
                end else begin
                  state <= ST_IGN;
                end
              end else if (state == ST_PTR) begin
                ptr   <= sh[AW-1:0];
                oe    <= 1'b1;
                state <= ST_ACK;
                nxt   <= ST_WDATA;
              end else begin
                we_o    <= 1'b1;
                waddr_o <= ptr;
                wdata_o <= sh;
                ptr     <= ptr + 1'b1;
                oe      <= 1'b1;
                state   <= ST_ACK;
                nxt     <= ST_WDATA;
              end
            end
          end
          ST_ACK: begin
            if (fall_i) begin
              state <= nxt;
              cnt   <= '0;
              if (nxt == ST_RD) begin
                tx  <= rdata_i;
                oe  <= ~rdata_i[7];
                ptr <= ptr + 1'b1;
              end else begin
                oe <= 1'b0;
              end
            end
          end
          ST_RD: begin
            if (rise_i) begin
              cnt <= cnt + 4'd1;
            end else if (fall_i) begin
              if (cnt == 4'd8) begin
                oe    <= 1'b0;
                state <= ST_RACK;
              end else begin
                oe <= ~tx[3'd7 - cnt[2:0]];
              end
            end
          end
          ST_RACK: begin
            if (rise_i) begin
              mack <= ~sda_s_i;
            end else if (fall_i) begin
              if (mack) begin
                tx    <= rdata_i;
                oe    <= ~rdata_i[7];
                ptr   <= ptr + 1'b1;
                cnt   <= '0;
                state <= ST_RD;
              end else begin
                state <= ST_IGN;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ptr_o    = ptr;
  assign sda_oe_o = oe;
  assign state_o  = state;
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h50,
  parameter int unsigned DEPTH    = 256,
  localparam int unsigned AW      = $clog2(DEPTH)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  logic          scl_s, sda_s;
  logic          start_w, stop_w, rise_w, fall_w;
  logic          we_w;
  logic [AW-1:0] waddr_w, ptr_w;
  logic [7:0]    wdata_w, rdata_w;
  st_e           state_w;

  i2c_sync #(.W(2), .STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    ({scl_s, sda_s})
  );

  i2c_cond_det u_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_s_i (scl_s),
    .sda_s_i (sda_s),
    .start_o (start_w),
    .stop_o  (stop_w),
    .rise_o  (rise_w),
    .fall_o  (fall_w)
  );

  i2c_mem_array #(.DEPTH(DEPTH), .DW(8)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_w),
    .waddr_i (waddr_w),
    .wdata_i (wdata_w),
    .raddr_i (ptr_w),
    .rdata_o (rdata_w)
  );

  i2c_mem_fsm #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_w),
    .stop_i   (stop_w),
    .rise_i   (rise_w),
    .fall_i   (fall_w),
    .sda_s_i  (sda_s),
    .rdata_i  (rdata_w),
    .we_o     (we_w),
    .waddr_o  (waddr_w),
    .wdata_o  (wdata_w),
    .ptr_o    (ptr_w),
    .sda_oe_o (sda_oe_o),
    .state_o  (state_w)
  );
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk
  import i2c_mem_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_i,
  input logic          sda_oe_o,
  input logic          start_i,
  input st_e           state_i,
  input logic [AW-1:0] ptr_i
);
  assert_idle_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_IDLE |-> !sda_oe_o);

  assert_ack_drive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ACK && $past(state_i) != ST_ACK) |-> sda_oe_o);

  // covers mismatch (R3) and post-NACK silence (R7)
  assert_ign_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_IGN |-> !sda_oe_o);

  assert_ptr_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_i != $past(ptr_i) && $past(state_i) != ST_PTR) |-> ptr_i == $past(ptr_i) + 1'b1);

  assert_start_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(start_i) |-> state_i == ST_ADDR);

  assert_scl_low_change_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);
endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_i    (scl_i),
  .sda_oe_o (sda_oe_o),
  .start_i  (start_w),
  .state_i  (state_w),
  .ptr_i    (ptr_w)
);

// File: tb/tb_i2c_mem_slave.sv
module tb_i2c_mem_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 5;
  localparam logic [7:0] AW_BYTE = 8'hA0;
  localparam logic [7:0] AR_BYTE = 8'hA1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda_low = 1'b0;
  logic sda_oe;
  wire  sda_bus = ~(m_sda_low | sda_oe);

  int checks = 0;
  int errors = 0;
  int exp_val_q[$];
  string exp_tag_q[$];
  int obs_q[$];
  int r11_viol = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_mem_slave dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (m_scl),
    .sda_i    (sda_bus),
    .sda_oe_o (sda_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // monitor: compares observed items against expected ones in order
  initial begin
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0 && exp_val_q.size() > 0) begin
        int o, e;
        string t;
        o = obs_q.pop_front();
        e = exp_val_q.pop_front();
        t = exp_tag_q.pop_front();
        check(o, e, t);
      end
    end
  end

  // R11 watch: drive must not change while SCL is high
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && m_scl && (sda_oe !== oe_prev)) r11_viol++;
    oe_prev <= sda_oe;
  end

  task automatic expect_item(input int v, input string tag);
    exp_val_q.push_back(v);
    exp_tag_q.push_back(tag);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; tick(Q);
    m_scl = 1'b1;     tick(Q);
    m_sda_low = 1'b1; tick(Q);
    m_scl = 1'b0;     tick(Q);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; tick(Q);
    m_scl = 1'b1;     tick(Q);
    m_sda_low = 1'b0; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    m_sda_low = ~b; tick(Q);
    m_scl = 1'b1;   tick(2*Q);
    m_scl = 1'b0;   tick(Q);
  endtask

  task automatic get_bit(output logic b);
    m_sda_low = 1'b0; tick(Q);
    m_scl = 1'b1;     tick(Q);
    b = sda_bus;      tick(Q);
    m_scl = 1'b0;     tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, input int exp_ack, input string tag);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(a);
    expect_item(exp_ack, tag);
    obs_q.push_back(int'(a));
  endtask

  task automatic rd_byte(input logic [7:0] exp, input logic nack, input string tag);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    put_bit(nack);
    expect_item(int'(exp), tag);
    obs_q.push_back(int'(v));
  endtask

  task automatic random_read_start(input logic [7:0] p, input string tag);
    bus_start();
    wr_byte(AW_BYTE, 0, tag);
    wr_byte(p, 0, tag);
    bus_start();
    wr_byte(AR_BYTE, 0, tag);
  endtask

  initial begin
    logic b;
    tick(4);
    check(int'(sda_oe), 0, "R1 drive released in reset");
    rst_n = 1'b1;
    tick(4);
    check(int'(sda_oe), 0, "R1 drive released after reset");

    // R1/R2: read first, pointer 0, memory zero
    bus_start();
    wr_byte(AR_BYTE, 0, "R2 read address ack");
    rd_byte(8'h00, 1'b1, "R1 first read returns zero");
    bus_stop();

    // R4/R5: set pointer 0x10 and store four bytes
    bus_start();
    wr_byte(AW_BYTE, 0, "R2 write address ack");
    wr_byte(8'h10, 0, "R4 pointer byte ack");
    wr_byte(8'h11, 0, "R5 data ack");
    wr_byte(8'h22, 0, "R5 data ack");
    wr_byte(8'h33, 0, "R5 data ack");
    wr_byte(8'h44, 0, "R5 data ack");
    bus_stop();

    // R6/R7: random read three bytes then NACK
    random_read_start(8'h10, "R6 dummy write ack");
    rd_byte(8'h11, 1'b0, "R6 read byte 0");
    rd_byte(8'h22, 1'b0, "R6 read byte 1");
    rd_byte(8'h33, 1'b1, "R6 read byte 2");
    get_bit(b);
    check(int'(b), 1, "R7 line released after NACK");
    check(int'(sda_oe), 0, "R7 no drive after NACK");
    bus_stop();

    // R8: current-address read continues at 0x13
    bus_start();
    wr_byte(AR_BYTE, 0, "R8 read address ack");
    rd_byte(8'h44, 1'b1, "R8 current address read");
    bus_stop();

    // R3: wrong address, writes ignored
    bus_start();
    wr_byte(8'h42, 1, "R3 mismatch no ack");
    wr_byte(8'h10, 1, "R3 no ack after mismatch");
    wr_byte(8'hEE, 1, "R3 no ack after mismatch");
    bus_stop();
    random_read_start(8'h10, "R3 readback setup");
    rd_byte(8'h11, 1'b1, "R3 memory unchanged");
    bus_stop();

    // R9: wrap from 0xFF to 0x00
    bus_start();
    wr_byte(AW_BYTE, 0, "R9 address ack");
    wr_byte(8'hFF, 0, "R9 pointer ack");
    wr_byte(8'hAB, 0, "R9 data ack");
    wr_byte(8'hCD, 0, "R9 data ack");
    bus_stop();
    random_read_start(8'hFF, "R9 readback setup");
    rd_byte(8'hAB, 1'b0, "R9 top location");
    rd_byte(8'hCD, 1'b1, "R9 wrapped to zero");
    bus_stop();
    random_read_start(8'h00, "R9 readback setup");
    rd_byte(8'hCD, 1'b1, "R9 location zero holds wrapped byte");
    bus_stop();

    // R10: aborted byte then START
    bus_start();
    put_bit(1'b1);
    put_bit(1'b0);
    put_bit(1'b1);
    bus_start();
    wr_byte(AW_BYTE, 0, "R10 address after restart");
    wr_byte(8'h20, 0, "R10 pointer ack");
    wr_byte(8'h5A, 0, "R10 data ack");
    bus_stop();
    random_read_start(8'h20, "R10 readback setup");
    rd_byte(8'h5A, 1'b1, "R10 data stored");
    bus_stop();

    tick(10);
    check(r11_viol, 0, "R11 drive changes only with SCL low");
    check(exp_val_q.size(), 0, "scoreboard drained");
    finished = 1;
  end

  initial begin
    fork
      begin
        wait (finished);
      end
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule